// File: doc/BRIEF.md
# RMII receive elastic buffer

This block moves received di-bits from the receiver's recovered clock onto a reduced-pin receive interface. That interface is timed entirely by one 50 MHz reference clock. On each strobe the receiver side presents three things: a di-bit, its carrier-detect level and an error flag. The block buffers these entries in a 16-entry (32-bit) elastic store. The read and write pointers cross between the two clock domains as Gray codes through multi-flop synchronisers.

On the reference-clock side the block drives three outputs:
- `rxd`, the 2-bit received data.
- `crs_dv`, a single signal that merges carrier sense and data valid.
- `rx_er`, the error flag.

When a packet starts, `crs_dv` rises and `rxd` reads zero while the store pre-fills to a selectable threshold. The di-bits then stream out in order. After carrier is lost, the remaining di-bits drain while `crs_dv` alternates on nibble boundaries. `crs_dv` falls once the store is empty. An error flagged by the receiver replaces the data with an error symbol until the end of the packet. So does an overflow or underflow of the store, which also sets a sticky fault flag. In 10 Mbps mode the reference clock stays at 50 MHz and every di-bit is held for ten clocks.

Top module: `rmii_rx_elastic`

## Requirements
- R1: After reset, `rxd` is 00, and `crs_dv`, `rx_er` and `fifo_fault` are 0.
- R2: After `wr_carrier` rises, `crs_dv` goes to 1. Until the first buffered di-bit is delivered, `rxd` stays 00 and `rx_er` stays 0.
- R3: Delivery starts once the store holds the threshold. The threshold is 2 entries (4 bits) when `cfg_thr16` is 0 and 8 entries (16 bits) when it is 1. At 100 Mbps the 16-bit setting delays the first data by about six clocks more than the 4-bit setting.
- R4: Di-bits leave in the order they were written, with their values unchanged. Each pointer crosses domains in Gray code, which changes at most one bit per step.
- R5: `crs_dv` is 1 on every clock while the synchronised carrier remains present during a packet.
- R6: During the drain after carrier loss, `crs_dv` shows the di-bit's position within its nibble. It is 0 while an even-indexed di-bit is on `rxd` and 1 while an odd-indexed one is, with index 0 being the packet's first di-bit.
- R7: `crs_dv` returns to 0 in the di-bit slot that follows the last buffered di-bit. At the same time `rxd` returns to 00.
- R8: From the di-bit whose `wr_error` flag was set until `crs_dv` falls, `rx_er` is 1 and `rxd` is 10.
- R9: The error state clears when `crs_dv` falls, so a following clean packet is delivered with `rx_er` at 0 and unaltered data.
- R10: With `cfg_10m` at 0, each di-bit occupies one reference clock. With `cfg_10m` at 1, each di-bit is held on `rxd` for exactly ten consecutive reference clocks.
- R11: A write into a full store is dropped. The di-bits accepted after it in the same packet are marked, and they are delivered with `rx_er` at 1 and `rxd` at 10. Delivering a marked di-bit sets `fifo_fault`, which stays 1 until reset.
- R12: If the store runs empty while carrier is still present, the slot carries `rxd` 10 with `rx_er` at 1, the packet is treated as errored, and `fifo_fault` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst_n | input | 1 | Active-low reset, receive clock domain |
| wr_valid | input | 1 | Strobe: one di-bit presented this cycle |
| wr_dibit | input | 2 | Received di-bit |
| wr_carrier | input | 1 | Carrier detected by the receiver (level) |
| wr_error | input | 1 | Receive error flagged on this di-bit |
| ref_clk | input | 1 | 50 MHz reference clock for the output interface |
| ref_rst_n | input | 1 | Active-low reset, reference clock domain |
| cfg_10m | input | 1 | 1 selects 10 Mbps (ten clocks per di-bit) |
| cfg_thr16 | input | 1 | 1 selects the 16-bit pre-fill threshold, 0 the 4-bit one |
| rxd | output | 2 | Received di-bit toward the MAC |
| crs_dv | output | 1 | Merged carrier sense / data valid |
| rx_er | output | 1 | Receive error |
| fifo_fault | output | 1 | Sticky: store overflow or underflow seen |

## Verification
The hardest situation to reach from the ports is an overflow. With both clocks at the same rate the store never fills. The bench therefore selects 10 Mbps mode, which drains one entry every ten clocks, and writes a strobe on every receive clock. This fills the store within about sixteen cycles and forces dropped writes, then marked entries later in the same packet. Underflow is provoked differently: the write strobes stop while the carrier is held high, so the reader finds the store empty mid-packet.

// File: rtl/rmii_rxeb_pkg.sv
package rmii_rxeb_pkg;

   // One buffered slot: overflow marker, receiver error, data
   typedef struct packed {
      logic       ovf;
      logic       err;
      logic [1:0] dibit;
   } rxeb_entry_t;

   localparam int ENTRY_W = $bits(rxeb_entry_t);

   typedef enum logic [1:0] {
      RS_IDLE,
      RS_FILL,
      RS_FLOW
   } rxeb_state_t;

   localparam logic [1:0] ERR_SYM = 2'b10;

endpackage

// File: rtl/rxeb_sync.sv
module rxeb_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rxeb_sync needs at least two stages");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rxeb_wr.sv
module rxeb_wr
   import rmii_rxeb_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int STAGES = 2,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1
) (
   input  logic          wr_clk,
   input  logic          wr_rst_n,
   input  logic          wr_valid,
   input  logic [1:0]    wr_dibit,
   input  logic          wr_carrier,
   input  logic          wr_error,
   input  logic [PW-1:0] rd_gray,
   output logic [PW-1:0] wr_gray,
   output logic          carrier_w,
   input  logic [AW-1:0] rd_addr,
   output rxeb_entry_t   rd_entry
);

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [PW-1:0] wbin, rg_s, rbin_s, wbin_inc;
   logic          full, push, ovf_hold;
   rxeb_entry_t   mem [DEPTH];

   rxeb_sync #(.W(PW), .STAGES(STAGES)) u_rsync (
      .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rg_s)
   );

   assign rbin_s   = g2b(rg_s);
   assign full     = (wbin - rbin_s) == PW'(DEPTH);
   assign push     = wr_valid && !full;
   assign wbin_inc = wbin + 1'b1;

   always_ff @(posedge wr_clk) begin
      if (push) mem[wbin[AW-1:0]] <= '{ovf: ovf_hold, err: wr_error, dibit: wr_dibit};
   end

   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
         wbin      <= '0;
         wr_gray   <= '0;
         ovf_hold  <= 1'b0;
         carrier_w <= 1'b0;
      end else begin
         carrier_w <= wr_carrier;
         if (push) begin
            wbin    <= wbin_inc;
            wr_gray <= wbin_inc ^ (wbin_inc >> 1);
         end
         if (!wr_carrier)           ovf_hold <= 1'b0;
         else if (wr_valid && full) ovf_hold <= 1'b1;
      end
   end

   assign rd_entry = mem[rd_addr];

   // R4: write pointer moves by one Gray step at most
   p_gray_step_wr_r4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      $countones(wr_gray ^ $past(wr_gray)) <= 1);

   // R11: occupancy seen by the writer never exceeds the depth
   p_no_overflow_r11: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wbin - rbin_s) <= PW'(DEPTH));

endmodule

// File: rtl/rxeb_rd.sv
module rxeb_rd
   import rmii_rxeb_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int STAGES   = 2,
   parameter int TICK_DIV = 10,
   parameter int THR_LO   = 2,
   parameter int THR_HI   = 8,
   localparam int AW      = $clog2(DEPTH),
   localparam int PW      = AW + 1,
   localparam int DW      = $clog2(TICK_DIV)
) (
   input  logic          ref_clk,
   input  logic          ref_rst_n,
   input  logic          cfg_10m,
   input  logic          cfg_thr16,
   input  logic [PW-1:0] wr_gray,
   input  logic          carrier_w,
   output logic [PW-1:0] rd_gray,
   output logic [AW-1:0] rd_addr,
   input  rxeb_entry_t   rd_entry,
   output logic [1:0]    rxd,
   output logic          crs_dv,
   output logic          rx_er,
   output logic          fifo_fault
);

   localparam logic [PW-1:0] THR_LO_P = PW'(THR_LO);
   localparam logic [PW-1:0] THR_HI_P = PW'(THR_HI);
   localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [PW-1:0] wg_s, wbin_s, rbin, rbin_inc, fill, thr;
   logic          crs_s, empty, hold;
   logic          emit, starve, end_pkt, err_now;
   rxeb_state_t   state, n_state;
   logic [DW-1:0] div, n_div;
   logic [1:0]    n_rxd;
   logic          n_crs, n_er, elat, n_elat, phase, n_phase, n_fault;

   rxeb_sync #(.W(PW+1), .STAGES(STAGES)) u_wsync (
      .clk(ref_clk), .rst_n(ref_rst_n), .d({carrier_w, wr_gray}), .q({crs_s, wg_s})
   );

   assign wbin_s   = g2b(wg_s);
   assign fill     = wbin_s - rbin;
   assign empty    = (fill == '0);
   assign thr      = cfg_thr16 ? THR_HI_P : THR_LO_P;
   assign hold     = cfg_10m && (div != DIV_LAST);
   assign rd_addr  = rbin[AW-1:0];
   assign rbin_inc = rbin + 1'b1;
   assign err_now  = elat | rd_entry.err | rd_entry.ovf;

   always_comb begin
      n_state = state;  n_div = div;   n_rxd = rxd;   n_crs = crs_dv;
      n_er    = rx_er;  n_elat = elat; n_phase = phase; n_fault = fifo_fault;
      emit = 1'b0; starve = 1'b0; end_pkt = 1'b0;
      unique case (state)
         RS_IDLE: if (crs_s) begin
            n_state = RS_FILL; n_crs = 1'b1; n_rxd = 2'b00; n_er = 1'b0;
            n_elat  = 1'b0;    n_phase = 1'b0; n_div = '0;
         end
         RS_FILL: begin
            if (fill >= thr || (!crs_s && !empty)) emit = 1'b1;
            else if (!crs_s)                       end_pkt = 1'b1;
         end
         RS_FLOW: begin
            if (hold) begin
               n_div = div + 1'b1;
               if (crs_s) n_crs = 1'b1;
            end else if (!empty) emit = 1'b1;
            else if (crs_s)      starve = 1'b1;
            else                 end_pkt = 1'b1;
         end
         default: n_state = RS_IDLE;
      endcase
      if (emit) begin
         n_rxd   = err_now ? ERR_SYM : rd_entry.dibit;
         n_er    = err_now;
         n_elat  = err_now;
         n_crs   = crs_s | phase;
         n_phase = ~phase;
         n_fault = fifo_fault | rd_entry.ovf;
         n_state = RS_FLOW;
         n_div   = '0;
      end
      if (starve) begin
         n_rxd = ERR_SYM; n_er = 1'b1; n_elat = 1'b1; n_crs = 1'b1;
         n_phase = ~phase; n_fault = 1'b1; n_div = '0;
      end
      if (end_pkt) begin
         n_state = RS_IDLE; n_crs = 1'b0; n_rxd = 2'b00; n_er = 1'b0; n_elat = 1'b0;
      end
   end

   always_ff @(posedge ref_clk or negedge ref_rst_n) begin
      if (!ref_rst_n) begin
         state <= RS_IDLE; div <= '0; rxd <= 2'b00; crs_dv <= 1'b0; rx_er <= 1'b0;
         elat <= 1'b0; phase <= 1'b0; fifo_fault <= 1'b0; rbin <= '0; rd_gray <= '0;
      end else begin
         state <= n_state; div <= n_div; rxd <= n_rxd; crs_dv <= n_crs; rx_er <= n_er;
         elat <= n_elat; phase <= n_phase; fifo_fault <= n_fault;
         if (emit) begin
            rbin    <= rbin_inc;
            rd_gray <= rbin_inc ^ (rbin_inc >> 1);
         end
      end
   end

   // R4: read pointer moves by one Gray step at most
   p_gray_step_rd_r4: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      $countones(rd_gray ^ $past(rd_gray)) <= 1);

   // R2: during pre-fill the output is the quiet pattern with carrier high
   p_prefill_zero_r2: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      (state == RS_FILL) |-> (rxd == 2'b00 && crs_dv && !rx_er));

   // R5: carrier seen in an active packet keeps crs_dv high
   p_carrier_holds_r5: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      ($past(crs_s) && $past(state) != RS_IDLE) |-> crs_dv);

   // R6: a low crs_dv inside a packet is only ever an even-indexed di-bit
   p_drain_parity_r6: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      (state == RS_FLOW && !crs_dv) |-> phase);

   // R8: error flag always comes with the error symbol and lasts to packet end
   p_err_symbol_r8: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      rx_er |-> (rxd == ERR_SYM));
   p_err_to_end_r8: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      rx_er |=> (rx_er || !crs_dv));

   // R10: data is held between ten-clock ticks
   p_ten_hold_r10: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      (state == RS_FLOW && div != '0) |-> $stable(rxd));

   // R11: fault flag is sticky
   p_fault_sticky_r11: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      fifo_fault |=> fifo_fault);

endmodule

// File: rtl/rmii_rx_elastic.sv
module rmii_rx_elastic
   import rmii_rxeb_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int STAGES   = 2,
   parameter int TICK_DIV = 10,
   parameter int THR_LO   = 2,
   parameter int THR_HI   = 8
) (
   input  logic       wr_clk,
   input  logic       wr_rst_n,
   input  logic       wr_valid,
   input  logic [1:0] wr_dibit,
   input  logic       wr_carrier,
   input  logic       wr_error,
   input  logic       ref_clk,
   input  logic       ref_rst_n,
   input  logic       cfg_10m,
   input  logic       cfg_thr16,
   output logic [1:0] rxd,
   output logic       crs_dv,
   output logic       rx_er,
   output logic       fifo_fault
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if ((1 << AW) != DEPTH || DEPTH < 4) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (THR_LO < 1 || THR_HI <= THR_LO || THR_HI > DEPTH) begin : g_bad_thr
      $error("thresholds must satisfy 1 <= THR_LO < THR_HI <= DEPTH");
   end
   if (TICK_DIV < 2) begin : g_bad_div
      $error("TICK_DIV must be at least 2");
   end

   logic [PW-1:0] wr_gray, rd_gray;
   logic [AW-1:0] rd_addr;
   logic          carrier_w;
   rxeb_entry_t   rd_entry;

   rxeb_wr #(.DEPTH(DEPTH), .STAGES(STAGES)) u_wr (
      .wr_clk, .wr_rst_n, .wr_valid, .wr_dibit, .wr_carrier, .wr_error,
      .rd_gray, .wr_gray, .carrier_w, .rd_addr, .rd_entry
   );

   rxeb_rd #(.DEPTH(DEPTH), .STAGES(STAGES), .TICK_DIV(TICK_DIV),
             .THR_LO(THR_LO), .THR_HI(THR_HI)) u_rd (
      .ref_clk, .ref_rst_n, .cfg_10m, .cfg_thr16, .wr_gray, .carrier_w,
      .rd_gray, .rd_addr, .rd_entry, .rxd, .crs_dv, .rx_er, .fifo_fault
   );

endmodule

// File: tb/rmii_rx_elastic_test.sv
`timescale 1ns/1ps
module rmii_rx_elastic_test;

   logic       wr_clk = 1'b0, ref_clk = 1'b0;
   logic       wr_rst_n = 1'b0, ref_rst_n = 1'b0;
   logic       wr_valid = 1'b0, wr_carrier = 1'b0, wr_error = 1'b0;
   logic [1:0] wr_dibit = 2'b00;
   logic       cfg_10m = 1'b0, cfg_thr16 = 1'b0;
   logic [1:0] rxd;
   logic       crs_dv, rx_er, fifo_fault;

   int checks = 0, fails = 0;
   int p4 = 0, p16 = 0, pre = 0, zeros = 0;
   logic [1:0] cap_rxd [512];
   logic       cap_crs [512];
   logic       cap_er  [512];
   int         ncap = 0;

   rmii_rx_elastic uut (.*);

   initial forever #10 ref_clk = ~ref_clk;
   initial begin #7; forever #10 wr_clk = ~wr_clk; end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [1:0] pat(input int k);
      return 2'((k % 3) + 1);
   endfunction

   task automatic do_reset();
      wr_rst_n = 1'b0; ref_rst_n = 1'b0;
      repeat (5) @(negedge ref_clk);
      wr_rst_n = 1'b1; ref_rst_n = 1'b1;
      repeat (3) @(negedge ref_clk);
   endtask

   task automatic send(input int n, input int gap, input int err_idx, input int tail);
      @(negedge wr_clk);
      wr_carrier = 1'b1;
      for (int k = 0; k < n; k++) begin
         wr_valid = 1'b1; wr_dibit = pat(k); wr_error = (k == err_idx);
         @(negedge wr_clk);
         wr_valid = 1'b0; wr_error = 1'b0;
         if (k != n - 1) repeat (gap) @(negedge wr_clk);
      end
      repeat (tail) @(negedge wr_clk);
      wr_carrier = 1'b0;
      @(negedge wr_clk);
   endtask

   task automatic capture(input int n);
      ncap = n;
      for (int i = 0; i < n; i++) begin
         @(negedge ref_clk);
         cap_rxd[i] = rxd; cap_crs[i] = crs_dv; cap_er[i] = rx_er;
      end
   endtask

   // Examines one captured packet; hold is clocks per di-bit
   task automatic analyze(input int n, input int hold, input int err_idx,
                          input string dreq, output int prefill, output int nz);
      int s = -1, f = -1, e, bad_d = 0, bad_e = 0, bad_p = 0, bad_q = 0;
      logic [1:0] xd;
      logic xe;
      prefill = 0; nz = 0;
      for (int i = 0; i < ncap; i++) if (s < 0 && cap_crs[i]) s = i;
      check(s >= 0, "R2", "crs_dv rose", s, 0);
      if (s < 0) return;
      for (int i = s; i < ncap; i++) if (f < 0 && cap_rxd[i] != 2'b00) f = i;
      check(f > s, "R2", "data start index after crs_dv", f, s + 1);
      if (f <= s) return;
      prefill = f - s;
      for (int i = s; i < f; i++) if (!cap_crs[i] || cap_er[i]) bad_q++;
      check(bad_q == 0, "R5", "pre-fill crs_dv high and rx_er low, bad cycles", bad_q, 0);
      e = f + n * hold;
      if (e + 5 >= ncap) begin
         check(0, dreq, "capture window too short", e, ncap);
         return;
      end
      for (int k = 0; k < n; k++) begin
         xe = (err_idx >= 0 && k >= err_idx);
         xd = xe ? 2'b10 : pat(k);
         for (int j = 0; j < hold; j++) begin
            if (cap_rxd[f + k*hold + j] != xd) bad_d++;
            if (cap_er[f + k*hold + j] != xe) bad_e++;
         end
         if (!cap_crs[f + k*hold] && (k % 2) == 1) bad_p++;
         if (!cap_crs[f + k*hold]) nz++;
      end
      check(bad_d == 0, dreq, "data slots mismatching", bad_d, 0);
      check(bad_e == 0, (err_idx >= 0) ? "R8" : "R9", "rx_er slots mismatching", bad_e, 0);
      check(bad_p == 0, "R6", "odd di-bits with crs_dv low", bad_p, 0);
      check(cap_crs[f], "R5", "crs_dv on first data slot", int'(cap_crs[f]), 1);
      bad_q = 0;
      for (int i = e; i < e + 5; i++) if (cap_crs[i] || cap_rxd[i] != 2'b00) bad_q++;
      check(bad_q == 0, "R7", "cycles after last di-bit not idle", bad_q, 0);
   endtask

   task automatic t_reset();
      check(rxd == 2'b00, "R1", "rxd after reset", int'(rxd), 0);
      check(!crs_dv && !rx_er, "R1", "crs_dv|rx_er after reset", int'(crs_dv | rx_er), 0);
      check(!fifo_fault, "R1", "fifo_fault after reset", int'(fifo_fault), 0);
   endtask

   task automatic t_thr4();
      cfg_10m = 1'b0; cfg_thr16 = 1'b0;
      fork send(12, 0, -1, 0); capture(80); join
      analyze(12, 1, -1, "R4", p4, zeros);
      repeat (10) @(negedge ref_clk);
   endtask

   task automatic t_thr16();
      cfg_10m = 1'b0; cfg_thr16 = 1'b1;
      fork send(20, 0, -1, 0); capture(100); join
      analyze(20, 1, -1, "R4", p16, zeros);
      check(p16 - p4 >= 5 && p16 - p4 <= 7, "R3", "extra pre-fill clocks 16 vs 4 bit",
            p16 - p4, 6);
      check(p4 >= 1 && p4 <= 8, "R3", "pre-fill clocks at 4-bit threshold", p4, 4);
      check(zeros >= 1, "R6", "drain slots with crs_dv low", zeros, 1);
      repeat (10) @(negedge ref_clk);
      cfg_thr16 = 1'b0;
   endtask

   task automatic t_ten();
      cfg_10m = 1'b1;
      fork send(6, 9, -1, 0); capture(200); join
      analyze(6, 10, -1, "R10", pre, zeros);
      repeat (10) @(negedge ref_clk);
      cfg_10m = 1'b0;
   endtask

   task automatic t_error();
      fork send(10, 0, 4, 0); capture(80); join
      analyze(10, 1, 4, "R8", pre, zeros);
      repeat (10) @(negedge ref_clk);
      fork send(10, 0, -1, 0); capture(80); join
      analyze(10, 1, -1, "R9", pre, zeros);
      repeat (10) @(negedge ref_clk);
   endtask

   task automatic t_overflow();
      int er_seen = 0, bad_sym = 0;
      do_reset();
      cfg_10m = 1'b1;
      fork send(30, 0, -1, 0); capture(450); join
      for (int i = 0; i < ncap; i++) begin
         if (cap_er[i]) er_seen++;
         if (cap_er[i] && cap_rxd[i] != 2'b10) bad_sym++;
      end
      check(fifo_fault, "R11", "fifo_fault after overflow", int'(fifo_fault), 1);
      check(er_seen > 0, "R11", "rx_er clocks in overflowed packet", er_seen, 1);
      check(bad_sym == 0, "R11", "errored clocks without symbol 10", bad_sym, 0);
      check(!cap_crs[ncap-1], "R7", "crs_dv low after overflow drain", int'(cap_crs[ncap-1]), 0);
      repeat (30) @(negedge ref_clk);
      check(fifo_fault, "R11", "fifo_fault still set when idle", int'(fifo_fault), 1);
      cfg_10m = 1'b0;
   endtask

   task automatic t_underflow();
      int er_seen = 0, crs_gap = 0, s = -1;
      do_reset();
      check(!fifo_fault, "R12", "fifo_fault cleared by reset", int'(fifo_fault), 0);
      fork send(6, 0, -1, 20); capture(80); join
      for (int i = 0; i < ncap; i++) begin
         if (s < 0 && cap_crs[i]) s = i;
         if (cap_er[i] && cap_rxd[i] == 2'b10) er_seen++;
      end
      for (int i = (s < 0 ? 0 : s); i < (s < 0 ? 0 : s) + 20; i++) if (!cap_crs[i]) crs_gap++;
      check(fifo_fault, "R12", "fifo_fault after underflow", int'(fifo_fault), 1);
      check(er_seen > 0, "R12", "error-symbol clocks after starving", er_seen, 1);
      check(crs_gap == 0, "R12", "crs_dv low while carrier held", crs_gap, 0);
   endtask

   initial begin
      #4_000_000;
      fails++;
      $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      do_reset();
      t_reset();
      t_thr4();
      t_thr16();
      t_ten();
      t_error();
      t_overflow();
      t_underflow();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule